// File: doc/BRIEF.md
# LED Bank Current and Enable Controller

This block is the control core of a five-output LED current-sink driver. A write port, fed by the single-wire serial decoder, loads six small control registers: per-sink enables, one current code for each of three banks, a fade-rate field and a grouping code. The grouping code assigns each sink to the main, sub or third bank. Each sink then receives an enable and a 5-bit current code. Sinks in the main bank take their code from the fader's running level, not from the stored main target.

The block also protects the outputs. A sink that reports an open circuit while driven is latched off until software rewrites the enable register. An over-temperature flag turns every output off without touching the registers, and the outputs resume when the flag clears. Two indications go to the power section. One is a sleep request raised when no sink is driven. The other is a low-quiescent indication raised when no driven sink is set above 4.0 mA.

Top module: `led_bank_ctrl`

## Requirements
- R1: While and after reset, every register is zero. All sinks are off with code 0, `sleep_req` is 1, `low_iq` is 1, `main_target` is 0 and `fade_rate` is 0.
- R2: Bit i of register 00h enables sink i+1 (active high, bit 0 is sink 1, bits 4:0 used). A write takes effect on the outputs in the cycle after the write edge.
- R3: Grouping register 05h (bits 2:0) selects the bank map. Code 000 puts sinks 1-5 in main. Code 001 puts sinks 1-3 in main and sinks 4-5 in sub. Code 010 puts sinks 1-2 in main, sinks 3-4 in sub and sink 5 in third. Codes 011-111 act as 000. A driven sink outputs its bank's code: register 02h bits 4:0 for sub, register 03h bits 4:0 for third.
- R4: Main-bank sinks output the `fade_level` input, combinationally. Register 01h bits 4:0 appear on `main_target` only.
- R5: A sink whose bank code is 00h is off even when its enable bit is set. A disabled sink outputs code 0.
- R6: A driven sink whose `open_ckt` bit is high at a clock edge is off from the next cycle. It stays off after `open_ckt` falls, until any write to register 00h clears all latched faults. A clear in the same cycle as a new open circuit wins.
- R7: While `over_temp` is high, every sink is off in that same cycle. All registers and latched faults keep their values, and the outputs return when the flag falls.
- R8: `sleep_req` is high exactly when no sink is driven.
- R9: `low_iq` is high exactly when every driven sink's code maps to 4.0 mA or less. Codes 00h-03h map to 0 mA. Code c in 04h-0Dh maps to (c-3)x0.5 mA. Code c in 0Eh-1Dh maps to 5+(c-13) mA. Codes 1Eh and 1Fh map to 23 and 25 mA. The limit is therefore code 0Bh.
- R10: Register 04h bits 1:0 drive `fade_rate`. A write to any address 06h or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 6 | Register write data |
| fade_level | input | 5 | Present faded main-bank code from the fader |
| open_ckt | input | 5 | Per-sink open-circuit indication, bit 0 is sink 1 |
| over_temp | input | 1 | Over-temperature flag |
| main_target | output | 5 | Stored main-bank target code for the fader |
| fade_rate | output | 2 | Stored fade-rate field for the fader |
| sink_en | output | 5 | Per-sink enable, bit 0 is sink 1 |
| sink_code | output | 25 | Per-sink current code, sink i+1 in bits 5i+4:5i |
| sleep_req | output | 1 | No sink driven |
| low_iq | output | 1 | No driven sink above 4.0 mA |

## Verification
Register writes and fault latching are registered, so their results are due in the cycle after the capturing edge. Changes on `fade_level` and `over_temp` reach `sink_en`, `sink_code`, `sleep_req` and `low_iq` in the same cycle. The bench drives inputs 1 ns after each rising edge and compares every output on the falling edge against a behavioural model. That model advances its registers and fault bits on the rising edge, using the inputs that were present before the edge. Directed checks sample on the same falling edge, so each one sees the first cycle in which its result is due.

// File: rtl/led_bank_pkg.sv
package led_bank_pkg;

  localparam int SINK_N   = 5;
  localparam int LVL_W    = 5;
  localparam int GROUP_W  = 3;
  localparam int RATE_W   = 2;
  localparam int REG_W    = 6;
  localparam int REGADR_W = 5;

  localparam int unsigned LOW_IQ_LIMIT_UA = 4000;

  typedef enum logic [1:0] {
    BANK_MAIN  = 2'd0,
    BANK_SUB   = 2'd1,
    BANK_THIRD = 2'd2
  } bank_e;

  // Bank owning zero-based sink index idx under grouping code grp.
  function automatic bank_e bank_of(input logic [GROUP_W-1:0] grp, input int unsigned idx);
    bank_e b;
    b = BANK_MAIN;
    case (grp)
      3'b001: if (idx >= 3) b = BANK_SUB;
      3'b010: begin
        if (idx >= 4)      b = BANK_THIRD;
        else if (idx >= 2) b = BANK_SUB;
      end
      default: b = BANK_MAIN;
    endcase
    return b;
  endfunction

  // Nominal sink current in microamps for a current code.
  function automatic int unsigned code_to_ua(input logic [LVL_W-1:0] code);
    int unsigned c;
    c = 32'(code);
    if (c < 4)        return 0;
    else if (c <= 13) return (c - 3) * 500;
    else if (c <= 29) return 5000 + (c - 13) * 1000;
    else              return 21000 + (c - 29) * 2000;
  endfunction

endpackage

// File: rtl/led_ctrl_regs.sv
module led_ctrl_regs
  import led_bank_pkg::*;
#(
  parameter int ADDR_W = REGADR_W,
  parameter int DATA_W = REG_W,
  parameter int N_SINK = SINK_N,
  parameter int CODE_W = LVL_W,
  parameter int FADE_W = RATE_W,
  parameter int GRP_W  = GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_SINK-1:0] en_bits,
  output logic [CODE_W-1:0] main_lvl,
  output logic [CODE_W-1:0] sub_lvl,
  output logic [CODE_W-1:0] third_lvl,
  output logic [FADE_W-1:0] rate,
  output logic [GRP_W-1:0]  grp,
  output logic              en_write
);

  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MAIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SUB   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_THIRD = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RATE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_GRP   = ADDR_W'(5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bits   <= '0;
      main_lvl  <= '0;
      sub_lvl   <= '0;
      third_lvl <= '0;
      rate      <= '0;
      grp       <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_EN:    en_bits   <= wr_data[N_SINK-1:0];
        A_MAIN:  main_lvl  <= wr_data[CODE_W-1:0];
        A_SUB:   sub_lvl   <= wr_data[CODE_W-1:0];
        A_THIRD: third_lvl <= wr_data[CODE_W-1:0];
        A_RATE:  rate      <= wr_data[FADE_W-1:0];
        A_GRP:   grp       <= wr_data[GRP_W-1:0];
        default: ;
      endcase
    end
  end

  // Named event: a write that rewrites every enable bit.
  assign en_write = wr_en && (wr_addr == A_EN);

  assert_ignore_high_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > A_GRP)) |=> $stable({en_bits, main_lvl, sub_lvl, third_lvl, rate, grp}))
    else $error("write above the register range changed state");

endmodule

// File: rtl/led_float_latch.sv
module led_float_latch
  import led_bank_pkg::*;
#(
  parameter int N_SINK = SINK_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [N_SINK-1:0] driven,
  input  logic [N_SINK-1:0] open_ckt,
  output logic [N_SINK-1:0] fault
);

  logic [N_SINK-1:0] new_fault;
  assign new_fault = driven & open_ckt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fault <= '0;
    else if (clear) fault <= '0;
    else            fault <= fault | new_fault;
  end

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((fault & $past(fault)) == $past(fault)))
    else $error("latched float fault dropped without an enable write");

  assert_fault_catch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && (new_fault != '0)) |=> ((fault & $past(new_fault)) == $past(new_fault)))
    else $error("open circuit on a driven sink not latched");

endmodule

// File: rtl/led_sink_map.sv
module led_sink_map
  import led_bank_pkg::*;
#(
  parameter int N_SINK = SINK_N,
  parameter int CODE_W = LVL_W,
  parameter int GRP_W  = GROUP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GRP_W-1:0]         grp,
  input  logic [CODE_W-1:0]        main_code,
  input  logic [CODE_W-1:0]        sub_code,
  input  logic [CODE_W-1:0]        third_code,
  input  logic [N_SINK-1:0]        en_bits,
  input  logic [N_SINK-1:0]        fault,
  input  logic                     over_temp,
  output logic [N_SINK-1:0]        sink_en,
  output logic [N_SINK*CODE_W-1:0] sink_code
);

  for (genvar i = 0; i < N_SINK; i++) begin : g_sink
    bank_e             bank;
    logic [CODE_W-1:0] lvl;
    logic              drive;

    always_comb begin
      bank = bank_of(grp, i);
      case (bank)
        BANK_SUB:   lvl = sub_code;
        BANK_THIRD: lvl = third_code;
        default:    lvl = main_code;
      endcase
    end

    assign drive = en_bits[i] && (lvl != '0) && !fault[i] && !over_temp;
    assign sink_en[i] = drive;
    assign sink_code[i*CODE_W +: CODE_W] = drive ? lvl : '0;

    assert_zero_code_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sink_code[i*CODE_W +: CODE_W] == '0) |-> !sink_en[i])
      else $error("sink driven with a zero current code");

    assert_fault_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault[i] |-> !sink_en[i])
      else $error("faulted sink still driven");
  end

endmodule

// File: rtl/led_bank_ctrl.sv
module led_bank_ctrl
  import led_bank_pkg::*;
#(
  parameter int ADDR_W = REGADR_W,
  parameter int DATA_W = REG_W,
  parameter int N_SINK = SINK_N,
  parameter int CODE_W = LVL_W,
  parameter int FADE_W = RATE_W,
  parameter int GRP_W  = GROUP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [CODE_W-1:0]        fade_level,
  input  logic [N_SINK-1:0]        open_ckt,
  input  logic                     over_temp,
  output logic [CODE_W-1:0]        main_target,
  output logic [FADE_W-1:0]        fade_rate,
  output logic [N_SINK-1:0]        sink_en,
  output logic [N_SINK*CODE_W-1:0] sink_code,
  output logic                     sleep_req,
  output logic                     low_iq
);

  logic [N_SINK-1:0] en_bits;
  logic [N_SINK-1:0] fault;
  logic [CODE_W-1:0] sub_lvl;
  logic [CODE_W-1:0] third_lvl;
  logic [GRP_W-1:0]  grp;
  logic              en_write;

  led_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SINK(N_SINK),
    .CODE_W(CODE_W), .FADE_W(FADE_W), .GRP_W(GRP_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_bits(en_bits), .main_lvl(main_target), .sub_lvl(sub_lvl),
    .third_lvl(third_lvl), .rate(fade_rate), .grp(grp), .en_write(en_write)
  );

  led_sink_map #(.N_SINK(N_SINK), .CODE_W(CODE_W), .GRP_W(GRP_W)) map_i (
    .clk(clk), .rst_n(rst_n), .grp(grp), .main_code(fade_level),
    .sub_code(sub_lvl), .third_code(third_lvl), .en_bits(en_bits),
    .fault(fault), .over_temp(over_temp), .sink_en(sink_en), .sink_code(sink_code)
  );

  led_float_latch #(.N_SINK(N_SINK)) flt_i (
    .clk(clk), .rst_n(rst_n), .clear(en_write), .driven(sink_en),
    .open_ckt(open_ckt), .fault(fault)
  );

  assign sleep_req = (sink_en == '0);

  always_comb begin
    low_iq = 1'b1;
    for (int i = 0; i < N_SINK; i++) begin
      if (sink_en[i] && (code_to_ua(sink_code[i*CODE_W +: CODE_W]) > LOW_IQ_LIMIT_UA))
        low_iq = 1'b0;
    end
  end

  assert_ot_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> (sink_en == '0))
    else $error("sink driven during over-temperature");

  assert_ot_keeps_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && !en_write) |=> ((fault & $past(fault)) == $past(fault)))
    else $error("over-temperature lost latched faults");

  assert_sleep_no_current_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (sink_code == '0))
    else $error("sleep requested while a sink carries current");

  assert_low_iq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> low_iq)
    else $error("low-quiescent indication missing with no sink driven");

endmodule

// File: tb/led_bank_ctrl_tb_top.sv
module led_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [5:0]  wr_data = '0;
  logic [4:0]  fade_level = '0;
  logic [4:0]  open_ckt = '0;
  logic        over_temp = 1'b0;
  logic [4:0]  main_target;
  logic [1:0]  fade_rate;
  logic [4:0]  sink_en;
  logic [24:0] sink_code;
  logic        sleep_req;
  logic        low_iq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  led_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fade_level(fade_level), .open_ckt(open_ckt), .over_temp(over_temp),
    .main_target(main_target), .fade_rate(fade_rate), .sink_en(sink_en),
    .sink_code(sink_code), .sleep_req(sleep_req), .low_iq(low_iq)
  );

  // Behavioural reference state
  int m_en, m_main, m_sub, m_third, m_rate, m_grp;
  bit [4:0] m_flt;

  function automatic int level_of(int s); // s = 1..5
    int b;
    b = 0;
    if (m_grp == 1 && s >= 4) b = 1;
    if (m_grp == 2) b = (s <= 2) ? 0 : ((s <= 4) ? 1 : 2);
    if (b == 1) return m_sub;
    if (b == 2) return m_third;
    return int'(fade_level);
  endfunction

  function automatic bit [4:0] exp_en();
    bit [4:0] e;
    for (int s = 1; s <= 5; s++)
      e[s-1] = m_en[s-1] && (level_of(s) != 0) && !m_flt[s-1] && !over_temp;
    return e;
  endfunction

  function automatic int half_ma(int c);
    if (c < 4)   return 0;
    if (c <= 13) return c - 3;
    if (c <= 29) return 10 + 2 * (c - 13);
    return 42 + 4 * (c - 29);
  endfunction

  function automatic bit exp_low();
    bit [4:0] e;
    e = exp_en();
    for (int s = 1; s <= 5; s++)
      if (e[s-1] && half_ma(level_of(s)) > 8) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model_step
    bit [4:0] e;
    if (!rst_n) begin
      m_en = 0; m_main = 0; m_sub = 0; m_third = 0; m_rate = 0; m_grp = 0; m_flt = '0;
    end else begin
      e = exp_en();
      if (wr_en && wr_addr == 5'd0) m_flt = '0;
      else m_flt = m_flt | (e & open_ckt);
      if (wr_en) begin
        case (wr_addr)
          5'd0: m_en    = int'(wr_data[4:0]);
          5'd1: m_main  = int'(wr_data[4:0]);
          5'd2: m_sub   = int'(wr_data[4:0]);
          5'd3: m_third = int'(wr_data[4:0]);
          5'd4: m_rate  = int'(wr_data[1:0]);
          5'd5: m_grp   = int'(wr_data[2:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int code_of(int s);
    return int'(sink_code[(s-1)*5 +: 5]);
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin : cmp
    bit [4:0] e;
    if (model_on && rst_n) begin
      e = exp_en();
      chk("R2 model sink_en", int'(sink_en), int'(e));
      for (int s = 1; s <= 5; s++)
        chk("R3 model sink_code", code_of(s), e[s-1] ? level_of(s) : 0);
      chk("R8 model sleep_req", int'(sleep_req), int'(e == 5'd0));
      chk("R9 model low_iq", int'(low_iq), int'(exp_low()));
      chk("R4 model main_target", int'(main_target), m_main);
      chk("R10 model fade_rate", int'(fade_rate), m_rate);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 6'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset sink_en", int'(sink_en), 0);
    chk("R1 reset sink_code", int'(sink_code), 0);
    chk("R1 reset sleep_req", int'(sleep_req), 1);
    chk("R1 reset low_iq", int'(low_iq), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk("R1 after reset main_target", int'(main_target), 0);
    chk("R1 after reset fade_rate", int'(fade_rate), 0);

    // Main bank, all sinks, faded level used
    wr(1, 6'h10);
    fade_level = 5'h10;
    wr(0, 6'h3F);
    @(negedge clk);
    chk("R2 all enabled", int'(sink_en), 5'h1F);
    chk("R4 main uses fade_level", code_of(3), 5'h10);
    chk("R4 main_target holds register", int'(main_target), 5'h10);
    chk("R9 16 code above limit", int'(low_iq), 0);
    @(posedge clk); #1 fade_level = 5'h0B;
    @(negedge clk);
    chk("R9 code 0Bh at limit", int'(low_iq), 1);
    @(posedge clk); #1 fade_level = 5'h0C;
    @(negedge clk);
    chk("R9 code 0Ch above limit", int'(low_iq), 0);

    // Grouping
    wr(2, 6'h07);
    wr(3, 6'h1F);
    wr(5, 6'h01);
    @(negedge clk);
    chk("R3 grp001 sink4 sub", code_of(4), 7);
    chk("R3 grp001 sink3 main", code_of(3), 5'h0C);
    wr(5, 6'h02);
    @(negedge clk);
    chk("R3 grp010 sink5 third", code_of(5), 5'h1F);
    chk("R3 grp010 sink3 sub", code_of(3), 7);
    @(posedge clk); #1 fade_level = 5'h00;
    @(negedge clk);
    chk("R5 zero main code disables sinks1-2", int'(sink_en), 5'h1C);
    chk("R5 disabled sink code zero", code_of(1), 0);
    @(posedge clk); #1 fade_level = 5'h05;
    wr(5, 6'h07);
    @(negedge clk);
    chk("R3 grp111 falls back to main", code_of(5), 5);

    // Enable bits individually
    wr(0, 6'h05);
    @(negedge clk);
    chk("R2 bits 0 and 2 only", int'(sink_en), 5'h05);
    wr(0, 6'h1F);

    // Float fault
    @(posedge clk); #1 open_ckt = 5'b00100;
    @(negedge clk);
    chk("R6 fault not yet latched", int'(sink_en[2]), 1);
    @(posedge clk); #1 open_ckt = 5'b00000;
    @(negedge clk);
    chk("R6 sink3 latched off", int'(sink_en), 5'h1B);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 fault stays latched", int'(sink_en[2]), 0);
    wr(1, 6'h09);
    @(negedge clk);
    chk("R6 other write keeps fault", int'(sink_en[2]), 0);
    wr(0, 6'h1F);
    @(negedge clk);
    chk("R6 enable rewrite clears fault", int'(sink_en), 5'h1F);

    // Over-temperature
    @(posedge clk); #1 over_temp = 1'b1;
    @(negedge clk);
    chk("R7 outputs off same cycle", int'(sink_en), 0);
    chk("R8 sleep during over-temp", int'(sleep_req), 1);
    wr(7, 6'h2A);
    @(negedge clk);
    chk("R10 high address no effect", int'(main_target), 9);
    @(posedge clk); #1 over_temp = 1'b0;
    @(negedge clk);
    chk("R7 outputs resume", int'(sink_en), 5'h1F);
    chk("R7 registers kept", code_of(1), 5);

    // Fade field and sleep
    wr(4, 6'h3E);
    @(negedge clk);
    chk("R10 fade field", int'(fade_rate), 2);
    wr(0, 6'h00);
    @(negedge clk);
    chk("R8 sleep when all disabled", int'(sleep_req), 1);
    chk("R9 low_iq with none driven", int'(low_iq), 1);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule